// File: doc/BRIEF.md
# Latched Threshold Alarm and Warning Monitor

This block watches five 16-bit monitored quantities of an optical link endpoint: internal temperature, supply voltage, laser bias current, transmitted optical power and received optical power. Each quantity is compared against four programmable limits: a high alarm, a low alarm, a high warning and a low warning. The comparison happens once per measurement, when an upstream acquisition stage pulses a valid strobe. Any limit that is crossed sets a sticky flag.

A flag does not drop just because the quantity has returned to range. Software must first read the flags, which the host signals with a one-cycle read strobe. The flag then clears at the next measurement only if its own condition is absent at that measurement. While the laser is switched off, bias current and transmit power carry no meaning. Their flags, and any pending read marks on them, are frozen until the laser is enabled again.

Top module: `thr_alarm_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every flag output reads 0. All read marks are cleared by reset as well.
- R2: At a measurement, a high-alarm or high-warning flag is set when the value is strictly greater than its limit. A value equal to the limit does not set it.
- R3: At a measurement, a low-alarm or low-warning flag is set when the value is strictly less than its limit. A value equal to the limit does not set it.
- R4: Channel 0 (temperature) compares its value and limits as 16-bit two's-complement numbers. Channels 1 to 4 compare them as unsigned 16-bit numbers.
- R5: The channel order on `meas` is 0 temperature, 1 voltage, 2 bias, 3 transmit power, 4 receive power. Channel c occupies bits 16c+15..16c. Limit word i occupies bits 16i+15..16i of `limits`, with i = 4c + k, where k=0 is the high alarm, k=1 the low alarm, k=2 the high warning and k=3 the low warning.
- R6: A flag output changes only in the cycle after `meas_valid` is high. A cycle without `meas_valid` leaves all flags unchanged, whatever `meas`, `limits` or `flag_rd` carry.
- R7: Once set, a flag stays set at later measurements whose condition is absent, as long as no read has marked it.
- R8: A `flag_rd` pulse marks every flag that is set in that cycle as read. At the next measurement, a marked flag whose condition is absent clears. A read in the same cycle as `meas_valid` takes effect at that measurement.
- R9: If a marked flag's condition is present at a measurement, the flag stays set and its mark is consumed. A later measurement without the condition leaves it set until another read.
- R10: While `tx_off` is high at a measurement, the flags of channels 2 and 3 keep their values and their read marks persist. Channels 0, 1 and 4 update normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | One-cycle strobe: `meas` holds a new measurement set |
| meas | input | 80 | Five packed 16-bit measurements, channel 0 in the low bits |
| limits | input | 320 | Twenty packed 16-bit limit words, word 0 in the low bits |
| tx_off | input | 1 | Laser disabled; freezes the transmit-side channels |
| flag_rd | input | 1 | One-cycle strobe: the flags were read |
| hi_alarm | output | 5 | High-alarm flag per channel |
| lo_alarm | output | 5 | Low-alarm flag per channel |
| hi_warn | output | 5 | High-warning flag per channel |
| lo_warn | output | 5 | Low-warning flag per channel |

## Verification
The checker holds on every cycle that no flag moves without a measurement strobe. It also holds that the transmit-side flags stay put across a strobe taken with the laser off, that an above-limit receive power always raises its high alarm, and that a negative temperature never raises a high alarm whose limit is non-negative. The read-then-clear protocol depends on history across several strobes: marks persist, get consumed by a present condition, or survive a laser-off period. Only the bench's scenarios show it, by comparing the flags after each step against a reference model computed from the requirements.

// File: rtl/thrmon_pkg.sv
package thrmon_pkg;

    // Position of each limit kind inside one channel's group of limit words
    localparam int LIMS_PER_CH = 4;
    localparam int K_HI_ALM    = 0;
    localparam int K_LO_ALM    = 1;
    localparam int K_HI_WRN    = 2;
    localparam int K_LO_WRN    = 3;

    typedef logic [LIMS_PER_CH-1:0] lim_vec_t;

    // Registered state of one channel: its flags and their read marks
    typedef struct packed {
        lim_vec_t flg;
        lim_vec_t seen;
    } chan_state_t;

    // Even limit kinds are upper bounds, odd kinds are lower bounds
    function automatic logic is_upper(input int kind);
        return (kind % 2) == 0;
    endfunction

endpackage

// File: rtl/thrmon_cmp.sv
module thrmon_cmp
    import thrmon_pkg::*;
#(
    parameter int W          = 16,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic [W-1:0]             val,
    input  logic [LIMS_PER_CH*W-1:0] lims,
    output lim_vec_t                 crossed
);

    for (genvar k = 0; k < LIMS_PER_CH; k++) begin : g_lim
        logic [W-1:0] lim_w;
        assign lim_w = lims[k*W +: W];

        if (SIGNED_CMP) begin : g_signed
            if (is_upper(k)) begin : g_up
                assign crossed[k] = $signed(val) > $signed(lim_w);
            end else begin : g_dn
                assign crossed[k] = $signed(val) < $signed(lim_w);
            end
        end else begin : g_unsigned
            if (is_upper(k)) begin : g_up
                assign crossed[k] = val > lim_w;
            end else begin : g_dn
                assign crossed[k] = val < lim_w;
            end
        end
    end

endmodule

// File: rtl/thrmon_latch.sv
module thrmon_latch
    import thrmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sample,
    input  logic     hold,
    input  logic     rd,
    input  lim_vec_t crossed,
    output lim_vec_t flags
);

    chan_state_t st_d, st_q;
    lim_vec_t    marked;

    always_comb begin
        st_d   = st_q;
        // a read in this cycle marks whatever is currently latched
        marked = st_q.seen | (rd ? st_q.flg : '0);
        if (sample && !hold) begin
            // set dominates; a marked flag survives only if re-crossed
            st_d.flg  = crossed | (st_q.flg & ~marked);
            st_d.seen = '0;
        end else begin
            st_d.seen = marked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flg;

endmodule

// File: rtl/thr_alarm_monitor.sv
module thr_alarm_monitor
    import thrmon_pkg::*;
#(
    parameter int              NUM_CH      = 5,
    parameter int              W           = 16,
    parameter logic [NUM_CH-1:0] SIGNED_MASK = 5'b00001,
    parameter logic [NUM_CH-1:0] FREEZE_MASK = 5'b01100
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            meas_valid,
    input  logic [NUM_CH*W-1:0]             meas,
    input  logic [NUM_CH*LIMS_PER_CH*W-1:0] limits,
    input  logic                            tx_off,
    input  logic                            flag_rd,
    output logic [NUM_CH-1:0]               hi_alarm,
    output logic [NUM_CH-1:0]               lo_alarm,
    output logic [NUM_CH-1:0]               hi_warn,
    output logic [NUM_CH-1:0]               lo_warn
);

    localparam int GRP_W = LIMS_PER_CH * W;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        lim_vec_t crossed;
        lim_vec_t flags;
        logic     hold;

        assign hold = tx_off & FREEZE_MASK[c];

        thrmon_cmp #(
            .W          (W),
            .SIGNED_CMP (SIGNED_MASK[c])
        ) u_cmp (
            .val     (meas[c*W +: W]),
            .lims    (limits[c*GRP_W +: GRP_W]),
            .crossed (crossed)
        );

        thrmon_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .sample  (meas_valid),
            .hold    (hold),
            .rd      (flag_rd),
            .crossed (crossed),
            .flags   (flags)
        );

        assign hi_alarm[c] = flags[K_HI_ALM];
        assign lo_alarm[c] = flags[K_LO_ALM];
        assign hi_warn[c]  = flags[K_HI_WRN];
        assign lo_warn[c]  = flags[K_LO_WRN];
    end

endmodule

// File: rtl/thrmon_chk.sv
module thrmon_chk #(
    parameter int NUM_CH = 5,
    parameter int W      = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   meas_valid,
    input logic [NUM_CH*W-1:0]    meas,
    input logic [NUM_CH*4*W-1:0]  limits,
    input logic                   tx_off,
    input logic [NUM_CH-1:0]      hi_alarm,
    input logic [NUM_CH-1:0]      lo_alarm,
    input logic [NUM_CH-1:0]      hi_warn,
    input logic [NUM_CH-1:0]      lo_warn
);

    localparam int LAST = NUM_CH - 1;

    logic [4*NUM_CH-1:0] all_flags;
    assign all_flags = {lo_warn, hi_warn, lo_alarm, hi_alarm};

    // R6
    no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> $stable(all_flags));

    // R10
    tx_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && tx_off) |=>
            $stable({hi_alarm[3:2], lo_alarm[3:2], hi_warn[3:2], lo_warn[3:2]}));

    // R2
    rx_hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && (meas[LAST*W +: W] > limits[LAST*4*W +: W])) |=> hi_alarm[LAST]);

    // R4
    temp_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas[W-1] && !limits[W-1] && !hi_alarm[0]) |=> !hi_alarm[0]);

endmodule

bind thr_alarm_monitor thrmon_chk #(
    .NUM_CH (NUM_CH),
    .W      (W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas       (meas),
    .limits     (limits),
    .tx_off     (tx_off),
    .hi_alarm   (hi_alarm),
    .lo_alarm   (lo_alarm),
    .hi_warn    (hi_warn),
    .lo_warn    (lo_warn)
);

// File: tb/tb_thr_alarm_monitor.sv
`timescale 1ns/1ps
module tb_thr_alarm_monitor;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         meas_valid;
    logic [79:0]  meas;
    logic [319:0] limits;
    logic         tx_off;
    logic         flag_rd;
    logic [4:0]   hi_alarm, lo_alarm, hi_warn, lo_warn;

    int total = 0;
    int bad   = 0;

    // reference state, bit index = kind*5 + channel
    logic [19:0] m_flg;
    logic [19:0] m_seen;

    always #2.5 clk = ~clk;

    thr_alarm_monitor dut (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas(meas),
        .limits(limits), .tx_off(tx_off), .flag_rd(flag_rd),
        .hi_alarm(hi_alarm), .lo_alarm(lo_alarm), .hi_warn(hi_warn), .lo_warn(lo_warn)
    );

    function automatic logic crossed_of(int ch, int k, logic [15:0] v, logic [15:0] l);
        if (k % 2 == 0) return (ch == 0) ? ($signed(v) > $signed(l)) : (v > l);
        else            return (ch == 0) ? ($signed(v) < $signed(l)) : (v < l);
    endfunction

    task automatic set_meas(int ch, logic [15:0] v);
        meas[ch*16 +: 16] = v;
    endtask

    task automatic set_lim(int ch, int k, logic [15:0] v);
        limits[(ch*4+k)*16 +: 16] = v;
    endtask

    task automatic model_update();
        logic [19:0] mk;
        mk = m_seen | (flag_rd ? m_flg : 20'h0);
        for (int ch = 0; ch < 5; ch++) begin
            for (int k = 0; k < 4; k++) begin
                int i;
                i = k*5 + ch;
                if (meas_valid && !(tx_off && (ch == 2 || ch == 3))) begin
                    m_flg[i]  = crossed_of(ch, k, meas[ch*16 +: 16], limits[(ch*4+k)*16 +: 16])
                                | (m_flg[i] & ~mk[i]);
                    m_seen[i] = 1'b0;
                end else begin
                    m_seen[i] = mk[i];
                end
            end
        end
    endtask

    task automatic check(string tag);
        logic [19:0] got;
        got = {lo_warn, hi_warn, lo_alarm, hi_alarm};
        total++;
        if (got !== m_flg) begin
            bad++;
            $display("FAIL %s flags=%h expected=%h", tag, got, m_flg);
        end
    endtask

    // inputs already set after a falling edge; clock them in and compare
    task automatic step(logic v, logic rd, logic off, string tag);
        meas_valid = v;
        flag_rd    = rd;
        tx_off     = off;
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag);
        meas_valid = 1'b0;
        flag_rd    = 1'b0;
    endtask

    task automatic all_nominal();
        set_meas(0, 16'd6400);
        for (int ch = 1; ch < 5; ch++) set_meas(ch, 16'd500);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7731));
        rst_n = 1'b0; meas_valid = 1'b0; flag_rd = 1'b0; tx_off = 1'b0;
        meas = '0; limits = '0;
        m_flg = '0; m_seen = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R5 limit layout: temp in 1/256 C, the rest unsigned
        set_lim(0, 0, 16'd20480); set_lim(0, 1, 16'hF600);
        set_lim(0, 2, 16'd17920); set_lim(0, 3, 16'hFB00);
        for (int ch = 1; ch < 5; ch++) begin
            set_lim(ch, 0, 16'd1000); set_lim(ch, 1, 16'd100);
            set_lim(ch, 2, 16'd800);  set_lim(ch, 3, 16'd200);
        end
        all_nominal();
        step(1, 0, 0, "R2 R3 nominal none set");

        for (int ch = 1; ch < 5; ch++) set_meas(ch, 16'd1000);
        step(1, 0, 0, "R2 equal to high alarm");
        for (int ch = 1; ch < 5; ch++) set_meas(ch, 16'd1001);
        step(1, 0, 0, "R2 above high alarm");
        for (int ch = 1; ch < 5; ch++) set_meas(ch, 16'd100);
        step(1, 0, 0, "R3 equal to low alarm R7");
        for (int ch = 1; ch < 5; ch++) set_meas(ch, 16'd99);
        step(1, 0, 0, "R3 below low alarm R7");

        set_meas(0, 16'hF448);
        step(1, 0, 0, "R4 negative temperature");
        set_meas(0, 16'd20481);
        step(1, 0, 0, "R4 hot temperature");

        set_lim(1, 3, 16'd600);
        all_nominal();
        step(0, 1, 0, "R6 no strobe with read");
        set_meas(2, 16'hFFFF);
        step(0, 0, 0, "R6 no strobe with new value");

        step(1, 0, 0, "R8 marked flags clear");
        step(1, 0, 0, "R5 voltage low warning only");
        set_lim(1, 3, 16'd200);

        step(1, 1, 0, "R8 read with strobe");
        set_meas(4, 16'd2000);
        step(1, 0, 0, "R2 rx above");
        step(0, 1, 0, "R9 read");
        step(1, 0, 0, "R9 still crossed");
        set_meas(4, 16'd500);
        step(1, 0, 0, "R9 mark consumed");
        step(1, 1, 0, "R9 reread clears");

        set_meas(2, 16'd5000); set_meas(3, 16'd5000);
        step(1, 0, 1, "R10 frozen no set");
        step(1, 0, 0, "R10 released set");
        all_nominal();
        step(0, 1, 0, "R10 read");
        step(1, 0, 1, "R10 frozen keep mark");
        step(1, 0, 0, "R10 mark survives");

        for (int n = 0; n < 600; n++) begin
            if (n % 50 == 0) begin
                for (int i = 0; i < 20; i++)
                    limits[i*16 +: 16] = 16'($urandom_range(0, 65535));
            end
            for (int ch = 0; ch < 5; ch++) set_meas(ch, 16'($urandom_range(0, 65535)));
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) == 0),
                 1'($urandom_range(0, 3) == 0), "R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule